// File: doc/BRIEF.md
# Timed Note Request Player

The block plays one of seven tones for a set number of clock cycles whenever a requester asks for it. Seven square-wave generators run without pause from reset onward. Each one has its own half-period input. A request names a tone by a 3-bit number and is offered on a valid/ready handshake. Once the block accepts it, the block routes that generator to the single tone output for the requested number of cycles, and then returns to idle with the output held low.

Number 0 asks for a rest. The block is busy for the duration, but the output stays low. The generators are never restarted when a request is accepted. Whatever phase the chosen generator is in at that moment is the phase heard first, so the first half-cycle may be shortened. An output reports which tone is currently being played, and reads 0 when idle or resting.

Top module: `note_request_player`

## Requirements
- R1: While reset is high and on the first cycle after it, reqReady is 1, noteSel is 0 and toneOut is 0.
- R2: reqReady is 1 only while idle. A request is accepted on a rising edge where reqValid and reqReady are both 1. From the next cycle, reqReady is 0 and noteSel equals the accepted reqNote.
- R3: After acceptance, the block stays busy for durCycles cycles, with a value of 0 treated as 1. On the following cycle, noteSel is 0 and reqReady is 1.
- R4: While idle, noteSel is 0 and toneOut is 0.
- R5: The note number is captured at acceptance. Changes on reqNote, and reqValid pulses while busy, do not alter the tone being played and do not queue a second play.
- R6: Note number 0 is a rest. It keeps the block busy for the duration with toneOut low and noteSel 0.
- R7: Generator k (1..7) takes its half-period P from halfPer bits [(k-1)*16 +: 16]. Its first transition is a rise on the first edge after reset. It then stays high for P+1 cycles and low for P+1 cycles, repeating, for a full period of 2P+2 cycles.
- R8: While note k is playing, toneOut follows generator k's free-running waveform, including its phase at the moment of acceptance.
- R9: The duration is captured at acceptance. Changes on durCycles while busy do not shorten or lengthen the play.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| durCycles | input | 16 | Play length in cycles |
| halfPer | input | 112 | Seven 16-bit half-period values, tone 1 in the low bits |
| reqValid | input | 1 | Play request valid |
| reqReady | output | 1 | High while idle |
| reqNote | input | 3 | Requested note number, 0 means rest |
| noteSel | output | 3 | Note currently playing, 0 when idle or resting |
| toneOut | output | 1 | Selected square wave, low when silent |

## Verification
An accepted request shows on noteSel and reqReady one cycle after the accepting edge. The return to idle is due exactly max(durCycles,1) cycles after that. toneOut is combinational from registered state, so each generator's waveform is predicted from the count of edges since reset. The scoreboard's driver records each item at the accepting edge. The monitor then compares outputs on the falling edge of every cycle of the predicted play window and on the first idle cycle after it, so each result is sampled half a cycle after the register that produces it has updated.

// File: rtl/note_request_pkg.sv
package note_request_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PLAY = 1'b1
  } play_state_t;

  typedef struct packed {
    logic loadDur;
    logic decDur;
    logic captureNum;
    logic clearNum;
  } play_strobe_t;

endpackage

// File: rtl/tone_square_gen.sv
module tone_square_gen #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] halfPeriod,
  output logic             wave
);

  logic [PER_W-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt <= '0;
      wave     <= 1'b0;
    end else if (phaseCnt == '0) begin
      phaseCnt <= halfPeriod;
      wave     <= ~wave;
    end else begin
      phaseCnt <= phaseCnt - PER_W'(1);
    end
  end

  // R7: each level change reloads the half-period seen on the previous cycle
  p_reload_on_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(wave) |-> (phaseCnt == $past(halfPeriod)));

endmodule

// File: rtl/note_request_datapath.sv
module note_request_datapath
  import note_request_pkg::*;
#(
  parameter int NUM_NOTES = 7,
  parameter int PER_W     = 16,
  parameter int DUR_W     = 16,
  parameter int NUM_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  play_strobe_t               stb,
  input  logic [DUR_W-1:0]           durCycles,
  input  logic [NUM_NOTES*PER_W-1:0] halfPer,
  input  logic [NUM_W-1:0]           reqNote,
  output logic                       durLast,
  output logic [NUM_W-1:0]           noteSel,
  output logic                       toneOut
);

  localparam int SEL_SPAN = 1 << NUM_W;

  logic [DUR_W-1:0]    durCnt;
  logic [NUM_W-1:0]    selReg;
  logic [NUM_NOTES-1:0] tones;
  logic [SEL_SPAN-1:0]  tonesExt;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_NOTES; gi++) begin : g_tone
      tone_square_gen #(.PER_W(PER_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .halfPeriod (halfPer[gi*PER_W +: PER_W]),
        .wave       (tones[gi])
      );
    end
  endgenerate

  // slot 0 is the rest, unused slots above NUM_NOTES stay silent
  always_comb begin
    tonesExt = '0;
    tonesExt[NUM_NOTES:1] = tones;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      durCnt <= '0;
    end else if (stb.loadDur) begin
      durCnt <= durCycles;
    end else if (stb.decDur && durCnt != '0) begin
      durCnt <= durCnt - DUR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg <= '0;
    end else if (stb.captureNum) begin
      selReg <= reqNote;
    end else if (stb.clearNum) begin
      selReg <= '0;
    end
  end

  assign durLast = (durCnt <= DUR_W'(1));
  assign noteSel = selReg;
  assign toneOut = tonesExt[selReg];

  // R5: the selected note holds until the controller clears or reloads it
  p_hold_note_r5: assert property (@(posedge clk) disable iff (rst)
    (!stb.captureNum && !stb.clearNum) |=> $stable(selReg));

  // R3: counting runs one step per busy cycle
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (stb.decDur && !stb.loadDur && durCnt > DUR_W'(1)) |=> (durCnt == $past(durCnt) - DUR_W'(1)));

endmodule

// File: rtl/note_request_ctrl.sv
module note_request_ctrl
  import note_request_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         durLast,
  output logic         reqReady,
  output play_strobe_t stb
);

  play_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.loadDur    = 1'b1;
          stb.captureNum = 1'b1;
          stateNext      = ST_PLAY;
        end
      end
      ST_PLAY: begin
        if (durLast) begin
          stb.clearNum = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          stb.decDur = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);

  // R2: an accepted request drops ready on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);

  // R3: the last busy cycle is followed by idle
  p_finish_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!reqReady && durLast) |=> reqReady);

  // R5: no capture strobe while busy
  p_no_capture_busy_r5: assert property (@(posedge clk) disable iff (rst)
    !reqReady |-> !stb.captureNum);

endmodule

// File: rtl/note_request_player.sv
module note_request_player
  import note_request_pkg::*;
#(
  parameter int NUM_NOTES = 7,
  parameter int PER_W     = 16,
  parameter int DUR_W     = 16,
  parameter int NUM_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DUR_W-1:0]           durCycles,
  input  logic [NUM_NOTES*PER_W-1:0] halfPer,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [NUM_W-1:0]           reqNote,
  output logic [NUM_W-1:0]           noteSel,
  output logic                       toneOut
);

  play_strobe_t stb;
  logic         durLast;

  note_request_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .durLast  (durLast),
    .reqReady (reqReady),
    .stb      (stb)
  );

  note_request_datapath #(
    .NUM_NOTES (NUM_NOTES),
    .PER_W     (PER_W),
    .DUR_W     (DUR_W),
    .NUM_W     (NUM_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .durCycles (durCycles),
    .halfPer   (halfPer),
    .reqNote   (reqNote),
    .durLast   (durLast),
    .noteSel   (noteSel),
    .toneOut   (toneOut)
  );

  // R4: idle means silent and nothing selected
  p_idle_silent_r4: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (noteSel == '0 && !toneOut));

endmodule

// File: tb/note_request_player_test.sv
module note_request_player_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  durCycles = '0;
  logic [111:0] halfPer;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [2:0]   reqNote = '0;
  logic [2:0]   noteSel;
  logic         toneOut;

  int checks = 0;
  int failures = 0;
  int edgeCount = 0;
  bit monBusy = 1'b0;
  bit done = 1'b0;

  int perTab [7] = '{3, 4, 5, 6, 7, 8, 9};

  typedef struct { logic [2:0] num; int dur; } item_t;
  item_t expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < 7; k++) halfPer[k*16 +: 16] = 16'(perTab[k]);
  end

  note_request_player uut (
    .clk(clk), .rst(rst), .durCycles(durCycles), .halfPer(halfPer),
    .reqValid(reqValid), .reqReady(reqReady), .reqNote(reqNote),
    .noteSel(noteSel), .toneOut(toneOut)
  );

  always @(posedge clk) begin
    if (rst) edgeCount <= 0;
    else     edgeCount <= edgeCount + 1;
  end

  function automatic logic modelTone(logic [2:0] num);
    int p;
    if (num == 0) return 1'b0;
    p = perTab[num-1];
    return (((edgeCount - 1) / (p + 1)) % 2) == 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  // driver: offer a request, hold it until accepted, push expected item
  task automatic request(logic [2:0] num, int dur);
    bit r;
    forever begin
      @(negedge clk);
      r = reqReady;
      reqValid  = 1'b1;
      reqNote   = num;
      durCycles = 16'(dur);
      @(posedge clk);
      if (r) begin
        expQ.push_back('{num: num, dur: dur});
        break;
      end
    end
  endtask

  task automatic dropValid();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    forever begin
      @(posedge clk);
      if (!monBusy && expQ.size() == 0) break;
    end
    @(negedge clk);
  endtask

  // monitor
  initial begin
    item_t it;
    int d;
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        monBusy = 1'b1;
        it = expQ.pop_front();
        d = (it.dur == 0) ? 1 : it.dur;
        check("R2 ready low after accept", reqReady, 0);
        for (int i = 0; i < d; i++) begin
          if (i > 0) @(negedge clk);
          if (it.num == 0) begin
            check("R6 rest noteSel", noteSel, 0);
            check("R6 rest toneOut", toneOut, 0);
          end else begin
            check("R2/R5 noteSel holds captured note", noteSel, it.num);
            check("R7/R8 toneOut follows generator", toneOut, modelTone(it.num));
          end
          check("R3/R9 busy through duration", reqReady, 0);
        end
        @(negedge clk);
        check("R3 ready after duration", reqReady, 1);
        check("R4 idle noteSel", noteSel, 0);
        check("R4 idle toneOut", toneOut, 0);
        monBusy = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", reqReady, 1);
    check("R1 reset noteSel", noteSel, 0);
    check("R1 reset toneOut", toneOut, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle ready", reqReady, 1);
    check("R1 first cycle noteSel", noteSel, 0);

    // R4: idle with no request stays silent
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R4 idle toneOut", toneOut, 0);
      check("R4 idle noteSel", noteSel, 0);
    end

    // basic plays, R7/R8 phase over several periods
    request(3'd3, 12); dropValid(); drain();
    request(3'd7, 40);
    // R5/R9: busy-time changes and valid pulses are ignored
    @(negedge clk);
    reqValid = 1'b1; reqNote = 3'd2; durCycles = 16'd3;
    repeat (4) @(negedge clk);
    reqValid = 1'b0; reqNote = 3'd5; durCycles = 16'd90;
    drain();
    repeat (5) begin
      @(negedge clk);
      check("R5 busy request not queued", noteSel, 0);
    end

    // R6 rest
    request(3'd0, 6); dropValid(); drain();
    // R3 zero and one cycle durations
    request(3'd5, 0); dropValid(); drain();
    request(3'd1, 1); dropValid(); drain();
    // back-to-back, valid held through busy
    request(3'd4, 8);
    request(3'd6, 5);
    request(3'd2, 17); dropValid(); drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule